// File: doc/BRIEF.md
# Raster-Timed Interrupt Generator

This block raises two interrupts for a processor that runs beside a video unit. The first is a vertical-blank NMI, tied to the vertical counter crossing the visible-height limit. The second is a raster IRQ that fires when the horizontal position, the vertical position or both match values that software has programmed. The block watches the video horizontal and vertical dot counters and keeps a short history of each. It samples that history at fixed offsets into the past, which models the delay between the video logic and the interrupt logic.

Evaluation runs once per poll window of four master clocks. When a line asserts, it is protected by a hold flag for one window, so a status read in that window cannot clear it. The processor sees a pending flag for each interrupt and clears it with a one-cycle acknowledge pulse. Software programs a control register and two compare registers through a small write port. It reads each line through a status strobe, and the read clears the line.

Top module: `raster_irq_gen`

## Requirements
- R1: A free-running phase counter starts at 0 after reset and raises a poll tick on every fourth clock (phase 3). The NMI and IRQ conditions are evaluated only on a poll tick. The status outputs can rise only in the cycle after a tick.
- R2: At each poll, the NMI condition is whether the vertical counter as sampled 2 clocks earlier is greater than or equal to visHeight. A rising edge of the condition sets the NMI line (nmiStatus) and a falling edge clears it.
- R3: Setting the NMI line also sets an NMI hold. At the next poll the hold drops, and if the NMI enable is set, nmiPend is raised.
- R4: The IRQ condition requires at least one IRQ enable. With vertical enable set, the vertical counter from 10 clocks earlier must equal the vertical compare value. With horizontal enable set, the horizontal counter from 10 clocks earlier must equal the horizontal compare value.
- R5: The IRQ condition is false when the horizontal and vertical counters, both sampled 6 clocks earlier, are both zero.
- R6: A rising edge of the IRQ condition sets the IRQ line (irqStatus) and an IRQ hold. The hold is cleared at the next poll. At every poll, irqPend is raised if the line was set before that poll and an IRQ enable is set.
- R7: A write with wrAddr 0 loads the control register: bit 4 is the horizontal IRQ enable, bit 5 the vertical IRQ enable, bit 7 the NMI enable. wrAddr 1 loads the horizontal compare value and wrAddr 2 loads the vertical compare value. Poll evaluation in the write cycle uses the old values.
- R8: A control write with bit 5 set, bit 4 clear and the IRQ line set raises irqPend. A control write with bits 4 and 5 both clear clears the IRQ line and irqPend.
- R9: A control write that turns the NMI enable from 0 to 1 while the NMI line is set raises nmiPend.
- R10: nmiStatus shows the NMI line. An nmiRd strobe clears the line unless the NMI hold is active.
- R11: irqStatus shows the IRQ line. An irqRd strobe clears both the line and irqPend unless the IRQ hold is active.
- R12: nmiAck clears nmiPend and irqAck clears irqPend. A poll in the same cycle may raise the flag again. Within one cycle the order of effect is acknowledge, then poll, then write, then read.
- R13: Reset clears all lines, holds, pending flags, enables, compare values and counter history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hPos | input | CNT_W | Video horizontal dot counter |
| vPos | input | CNT_W | Video vertical line counter |
| visHeight | input | CNT_W | Visible height; lines at or beyond it are blanking |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 control, 1 horizontal compare, 2 vertical compare |
| wrData | input | CNT_W | Register write data |
| nmiRd | input | 1 | NMI status read strobe |
| irqRd | input | 1 | IRQ status read strobe |
| nmiAck | input | 1 | Processor acknowledge of a pending NMI |
| irqAck | input | 1 | Processor acknowledge of a pending IRQ |
| nmiPend | output | 1 | NMI transition pending to the processor |
| irqPend | output | 1 | IRQ transition pending to the processor |
| nmiStatus | output | 1 | NMI line, read data for the NMI status strobe |
| irqStatus | output | 1 | IRQ line, read data for the IRQ status strobe |

## Verification
The assertions check on every cycle that the lines rise only after a poll tick. They also check that an unheld status read clears its line, that an acknowledge outside a poll or write clears its pending flag, and that a control write with no IRQ enable leaves the IRQ line and flag cleared. The exact poll cycle in which a condition is seen depends on the 2-, 6- and 10-clock history taps. That, along with the hold windows, the last-dot guard and the write side effects, can only be shown by the bench. It sweeps enable combinations and compare values over a small raster, injects random writes, reads and acknowledges, and compares every cycle against a model built from the requirements.

// File: rtl/rig_pkg.sv
package rig_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_HCMP = 2'd1;
  localparam logic [1:0] ADDR_VCMP = 2'd2;

  localparam int BIT_HEN   = 4;
  localparam int BIT_VEN   = 5;
  localparam int BIT_NMIEN = 7;

  typedef struct packed {
    logic ctrlWr;
    logic hCmpWr;
    logic vCmpWr;
  } wrStb_t;

  typedef struct packed {
    logic nmiCond;
    logic irqCond;
  } cond_t;
endpackage

// File: rtl/rig_datapath.sv
module rig_datapath
  import rig_pkg::*;
#(
  parameter int CNT_W     = 9,
  parameter int TAP_NMI   = 2,
  parameter int TAP_GUARD = 6,
  parameter int TAP_IRQ   = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] hPos,
  input  logic [CNT_W-1:0] vPos,
  input  logic [CNT_W-1:0] visHeight,
  input  logic [CNT_W-1:0] wrData,
  input  wrStb_t           stb,
  output logic             hEn,
  output logic             vEn,
  output logic             nmiEn,
  output cond_t            cond
);
  localparam int HIST_D = (TAP_IRQ > TAP_GUARD)
                        ? ((TAP_IRQ > TAP_NMI) ? TAP_IRQ : TAP_NMI)
                        : ((TAP_GUARD > TAP_NMI) ? TAP_GUARD : TAP_NMI);

  logic [CNT_W-1:0] hHist [HIST_D];
  logic [CNT_W-1:0] vHist [HIST_D];
  logic [CNT_W-1:0] hCmp, vCmp;

  // counter history: entry k holds the value seen k+1 clocks ago
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < HIST_D; s++) begin
        hHist[s] <= '0;
        vHist[s] <= '0;
      end
    end else begin
      hHist[0] <= hPos;
      vHist[0] <= vPos;
      for (int s = 1; s < HIST_D; s++) begin
        hHist[s] <= hHist[s-1];
        vHist[s] <= vHist[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hEn   <= 1'b0;
      vEn   <= 1'b0;
      nmiEn <= 1'b0;
      hCmp  <= '0;
      vCmp  <= '0;
    end else begin
      if (stb.ctrlWr) begin
        hEn   <= wrData[BIT_HEN];
        vEn   <= wrData[BIT_VEN];
        nmiEn <= wrData[BIT_NMIEN];
      end
      if (stb.hCmpWr) hCmp <= wrData;
      if (stb.vCmpWr) vCmp <= wrData;
    end
  end

  logic vHit, hHit, notLastDot;
  always_comb begin
    vHit       = !vEn || (vHist[TAP_IRQ-1] == vCmp);
    hHit       = !hEn || (hHist[TAP_IRQ-1] == hCmp);
    notLastDot = (vHist[TAP_GUARD-1] != '0) || (hHist[TAP_GUARD-1] != '0);
    cond.nmiCond = (vHist[TAP_NMI-1] >= visHeight);
    cond.irqCond = (hEn || vEn) && vHit && hHit && notLastDot;
  end
endmodule

// File: rtl/rig_control.sv
module rig_control
  import rig_pkg::*;
#(
  parameter int CNT_W    = 9,
  parameter int POLL_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             nmiRd,
  input  logic             irqRd,
  input  logic             nmiAck,
  input  logic             irqAck,
  input  logic             hEn,
  input  logic             vEn,
  input  logic             nmiEn,
  input  cond_t            cond,
  output wrStb_t           stb,
  output logic             pollTick,
  output logic             nmiLine,
  output logic             irqLine,
  output logic             nmiHold,
  output logic             irqHold,
  output logic             nmiPend,
  output logic             irqPend
);
  localparam int PH_W = (POLL_DIV > 2) ? $clog2(POLL_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(POLL_DIV - 1);

  logic [PH_W-1:0] phase, phaseNx;
  logic nmiValid, irqValid;
  logic nNV, nNL, nNH, nNP, nIV, nIL, nIH, nIP;
  logic newH, newV;

  assign pollTick = (phase == PH_LAST);

  always_comb begin
    stb.ctrlWr = wrEn && (wrAddr == ADDR_CTRL);
    stb.hCmpWr = wrEn && (wrAddr == ADDR_HCMP);
    stb.vCmpWr = wrEn && (wrAddr == ADDR_VCMP);
  end

  always_comb begin
    phaseNx = pollTick ? '0 : phase + PH_W'(1);
    newH    = wrData[BIT_HEN];
    newV    = wrData[BIT_VEN];
    nNV = nmiValid; nNL = nmiLine; nNH = nmiHold; nNP = nmiPend;
    nIV = irqValid; nIL = irqLine; nIH = irqHold; nIP = irqPend;

    // 1: acknowledge
    if (nmiAck) nNP = 1'b0;
    if (irqAck) nIP = 1'b0;

    // 2: poll
    if (pollTick) begin
      if (nNH && nmiEn) nNP = 1'b1;
      nNH = 1'b0;
      if (cond.nmiCond != nNV) begin
        nNV = cond.nmiCond;
        nNL = cond.nmiCond;
        if (cond.nmiCond) nNH = 1'b1;
      end
      nIH = 1'b0;
      if (nIL && (hEn || vEn)) nIP = 1'b1;
      if (cond.irqCond && !nIV) begin
        nIL = 1'b1;
        nIH = 1'b1;
      end
      nIV = cond.irqCond;
    end

    // 3: control write side effects
    if (stb.ctrlWr) begin
      if (newV && !newH && nIL) begin
        nIP = 1'b1;
      end else if (!newV && !newH) begin
        nIL = 1'b0;
        nIP = 1'b0;
      end
      if (wrData[BIT_NMIEN] && !nmiEn && nNL) nNP = 1'b1;
    end

    // 4: status reads
    if (nmiRd && !nNH) nNL = 1'b0;
    if (irqRd && !nIH) begin
      nIL = 1'b0;
      nIP = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= '0;
      nmiValid <= 1'b0;
      nmiLine  <= 1'b0;
      nmiHold  <= 1'b0;
      nmiPend  <= 1'b0;
      irqValid <= 1'b0;
      irqLine  <= 1'b0;
      irqHold  <= 1'b0;
      irqPend  <= 1'b0;
    end else begin
      phase    <= phaseNx;
      nmiValid <= nNV;
      nmiLine  <= nNL;
      nmiHold  <= nNH;
      nmiPend  <= nNP;
      irqValid <= nIV;
      irqLine  <= nIL;
      irqHold  <= nIH;
      irqPend  <= nIP;
    end
  end
endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen
  import rig_pkg::*;
#(
  parameter int CNT_W     = 9,
  parameter int POLL_DIV  = 4,
  parameter int TAP_NMI   = 2,
  parameter int TAP_GUARD = 6,
  parameter int TAP_IRQ   = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] hPos,
  input  logic [CNT_W-1:0] vPos,
  input  logic [CNT_W-1:0] visHeight,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             nmiRd,
  input  logic             irqRd,
  input  logic             nmiAck,
  input  logic             irqAck,
  output logic             nmiPend,
  output logic             irqPend,
  output logic             nmiStatus,
  output logic             irqStatus
);
  wrStb_t stb;
  cond_t  cond;
  logic   hEn, vEn, nmiEn;
  logic   pollTick, nmiHold, irqHold;

  rig_datapath #(
    .CNT_W(CNT_W), .TAP_NMI(TAP_NMI), .TAP_GUARD(TAP_GUARD), .TAP_IRQ(TAP_IRQ)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hPos(hPos), .vPos(vPos), .visHeight(visHeight),
    .wrData(wrData), .stb(stb), .hEn(hEn), .vEn(vEn), .nmiEn(nmiEn), .cond(cond)
  );

  rig_control #(
    .CNT_W(CNT_W), .POLL_DIV(POLL_DIV)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .nmiRd(nmiRd), .irqRd(irqRd), .nmiAck(nmiAck), .irqAck(irqAck),
    .hEn(hEn), .vEn(vEn), .nmiEn(nmiEn), .cond(cond), .stb(stb),
    .pollTick(pollTick), .nmiLine(nmiStatus), .irqLine(irqStatus),
    .nmiHold(nmiHold), .irqHold(irqHold), .nmiPend(nmiPend), .irqPend(irqPend)
  );
endmodule

// File: rtl/raster_irq_gen_chk.sv
module raster_irq_gen_chk
  import rig_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             pollTick,
  input logic             wrEn,
  input logic [1:0]       wrAddr,
  input logic [CNT_W-1:0] wrData,
  input logic             nmiRd,
  input logic             irqRd,
  input logic             nmiAck,
  input logic             irqAck,
  input logic             nmiHold,
  input logic             irqHold,
  input logic             nmiStatus,
  input logic             irqStatus,
  input logic             nmiPend,
  input logic             irqPend
);
  logic ctrlWr;
  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);

  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    pollTick |=> !pollTick);

  a_r1_nmi_rise_after_poll: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiStatus) |-> $past(pollTick));

  a_r1_irq_rise_after_poll: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatus) |-> $past(pollTick));

  a_r8_disable_clears_irq: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !wrData[BIT_HEN] && !wrData[BIT_VEN]) |=> (!irqStatus && !irqPend));

  a_r10_nmi_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (nmiRd && !nmiHold && !pollTick) |=> !nmiStatus);

  a_r11_irq_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (irqRd && !irqHold && !pollTick) |=> (!irqStatus && !irqPend));

  a_r12_nmi_ack: assert property (@(posedge clk) disable iff (!rstN)
    (nmiAck && !pollTick && !ctrlWr) |=> !nmiPend);

  a_r12_irq_ack: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !pollTick && !ctrlWr) |=> !irqPend);
endmodule

bind raster_irq_gen raster_irq_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .pollTick(pollTick), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .nmiRd(nmiRd), .irqRd(irqRd), .nmiAck(nmiAck), .irqAck(irqAck),
  .nmiHold(nmiHold), .irqHold(irqHold), .nmiStatus(nmiStatus), .irqStatus(irqStatus),
  .nmiPend(nmiPend), .irqPend(irqPend)
);

// File: tb/test_raster_irq_gen.sv
module test_raster_irq_gen;
  localparam int CW = 9;
  localparam int HT = 16;
  localparam int VT = 10;
  localparam int VIS = 7;
  localparam int FRAME = HT * VT * 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic [CW-1:0] hPos, vPos, visHeight, wrData;
  logic wrEn, nmiRd, irqRd, nmiAck, irqAck;
  logic [1:0] wrAddr;
  logic nmiPend, irqPend, nmiStatus, irqStatus;

  raster_irq_gen #(.CNT_W(CW)) i_raster_irq_gen (
    .clk(clk), .rstN(rstN), .hPos(hPos), .vPos(vPos), .visHeight(visHeight),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .nmiRd(nmiRd), .irqRd(irqRd),
    .nmiAck(nmiAck), .irqAck(irqAck), .nmiPend(nmiPend), .irqPend(irqPend),
    .nmiStatus(nmiStatus), .irqStatus(irqStatus)
  );

  int nRun = 0, nFail = 0, cyc = 0, dotDiv = 0, irqSeen = 0;
  bit done = 0;

  // reference model built from the requirements
  int mPh;
  bit mNV, mNL, mNH, mNP, mIV, mIL, mIH, mIP, mH, mV, mN, poll, c, nh, nv;
  logic [CW-1:0] mHc, mVc;
  logic [CW-1:0] hq [10];
  logic [CW-1:0] vq [10];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh = 0; mNV = 0; mNL = 0; mNH = 0; mNP = 0; mIV = 0; mIL = 0; mIH = 0; mIP = 0;
      mH = 0; mV = 0; mN = 0; mHc = '0; mVc = '0;
      for (int i = 0; i < 10; i++) begin hq[i] = '0; vq[i] = '0; end
    end else begin
      poll = (mPh == 3);                       // R1
      mPh = (mPh + 1) % 4;
      if (nmiAck) mNP = 0;                     // R12
      if (irqAck) mIP = 0;
      if (poll) begin
        if (mNH && mN) mNP = 1;                // R3
        mNH = 0;
        c = (vq[1] >= visHeight);              // R2
        if (c != mNV) begin mNV = c; mNL = c; if (c) mNH = 1; end
        mIH = 0;
        if (mIL && (mH || mV)) mIP = 1;        // R6
        c = (mH || mV) && (!mV || vq[9] == mVc) && (!mH || hq[9] == mHc)
            && (vq[5] != 0 || hq[5] != 0);     // R4 R5
        if (c && !mIV) begin mIL = 1; mIH = 1; end
        mIV = c;
      end
      if (wrEn) begin                          // R7
        if (wrAddr == 2'd0) begin
          nh = wrData[4]; nv = wrData[5];
          if (nv && !nh && mIL) mIP = 1;       // R8
          else if (!nh && !nv) begin mIL = 0; mIP = 0; end
          if (wrData[7] && !mN && mNL) mNP = 1; // R9
          mH = nh; mV = nv; mN = wrData[7];
        end else if (wrAddr == 2'd1) mHc = wrData;
        else if (wrAddr == 2'd2) mVc = wrData;
      end
      if (nmiRd && !mNH) mNL = 0;              // R10
      if (irqRd && !mIH) begin mIL = 0; mIP = 0; end // R11
      for (int i = 9; i > 0; i--) begin hq[i] = hq[i-1]; vq[i] = vq[i-1]; end
      hq[0] = hPos; vq[0] = vPos;
    end
  end

  task automatic chk(input logic act, input logic exp, input string req);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  // one clock: compare outputs with the model, then drive the next inputs
  task automatic cycle(input string tag, input bit w, input logic [1:0] a,
                       input logic [CW-1:0] d, input int rdP, input int ackP);
    @(negedge clk);
    chk(nmiStatus, mNL, {"R2 nmiStatus ", tag});
    chk(nmiPend,   mNP, {"R3 nmiPend ", tag});
    chk(irqStatus, mIL, {"R4 irqStatus ", tag});
    chk(irqPend,   mIP, {"R6 irqPend ", tag});
    if (irqStatus) irqSeen++;
    dotDiv = (dotDiv + 1) % 4;
    if (dotDiv == 0) begin
      if (hPos == CW'(HT - 1)) begin
        hPos = '0;
        vPos = (vPos == CW'(VT - 1)) ? '0 : vPos + 1'b1;
      end else hPos = hPos + 1'b1;
    end
    wrEn = w; wrAddr = a; wrData = d;
    nmiRd  = (rdP  > 0) && ($urandom % rdP  == 0);
    irqRd  = (rdP  > 0) && ($urandom % rdP  == 0);
    nmiAck = (ackP > 0) && ($urandom % ackP == 0);
    irqAck = (ackP > 0) && ($urandom % ackP == 0);
  endtask

  task automatic config3(input logic [7:0] ctl, input int hc, input int vc, input string tag);
    cycle(tag, 1, 2'd1, CW'(hc), 0, 0);
    cycle(tag, 1, 2'd2, CW'(vc), 0, 0);
    cycle(tag, 1, 2'd0, CW'(ctl), 0, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      nFail++;
      $display("FAIL R1 watchdog expired actual=%0d expected<=200000", cyc);
      summary();
    end
  end

  initial begin
    int hcs [3] = '{0, 7, 15};
    int vcs [3] = '{0, 5, 9};
    rstN = 0; hPos = '0; vPos = '0; visHeight = CW'(VIS);
    wrEn = 0; wrAddr = '0; wrData = '0; nmiRd = 0; irqRd = 0; nmiAck = 0; irqAck = 0;
    repeat (3) @(negedge clk);
    // R13: reset state
    chk(nmiStatus, 1'b0, "R13 nmiStatus reset");
    chk(irqStatus, 1'b0, "R13 irqStatus reset");
    chk(nmiPend,   1'b0, "R13 nmiPend reset");
    chk(irqPend,   1'b0, "R13 irqPend reset");
    rstN = 1;

    // R1 R7: sweep all enable combinations against several compare positions
    for (int e = 0; e < 8; e++) begin
      for (int hi = 0; hi < 3; hi++) begin
        for (int vi = 0; vi < 3; vi++) begin
          config3({e[2], 1'b0, e[1], e[0], 4'b0}, hcs[hi], vcs[vi], "R1 R7 sweep");
          for (int k = 0; k < FRAME; k++) cycle("R1 R7 sweep", 0, 2'd0, '0, 40, 8);
        end
      end
    end

    // R5: both compares on the last dot of the field never fire
    config3(8'h30, HT - 1, VT - 1, "R5 guard");
    irqSeen = 0;
    for (int k = 0; k < 2 * FRAME; k++) cycle("R5 guard", 0, 2'd0, '0, 0, 0);
    chk(irqSeen != 0, 1'b0, "R5 no IRQ on last dot");

    // R8 R9: random control writes in mid-frame
    config3(8'h20, 5, 3, "R8 R9 writes");
    for (int k = 0; k < 4 * FRAME; k++) begin
      if ($urandom % 24 == 0)
        cycle("R8 R9 writes", 1, 2'd0, CW'({$urandom} & 32'hB0), 0, 6);
      else
        cycle("R8 R9 writes", 0, 2'd0, '0, 0, 6);
    end

    // R10 R11 R12: frequent status reads and acknowledges
    config3(8'hB0, 9, 2, "R10 R11 R12 reads");
    for (int k = 0; k < 4 * FRAME; k++) cycle("R10 R11 R12 reads", 0, 2'd0, '0, 6, 3);

    summary();
  end
endmodule